// File: doc/BRIEF.md
# Framed Streaming Multiply-Accumulator

This block is a scalar multiply-accumulator for streams of signed fixed-point samples. Each clock cycle it may take one pair of operands together with three flags: a qualifier that marks the pair as real data, a frame-open marker and a frame-close marker. A qualified pair with the frame-open marker loads the running sum with a constant bias plus the product of that pair. A qualified pair without the marker adds its product to the sum. Cycles without the qualifier leave the sum unchanged.

Every result and every flag comes out of a register, one cycle after the inputs that caused it. The frame markers are gated by the qualifier on the way through, so a consumer can cut frames out of the output stream using only the output flags. The multiplication is done at full precision. The running sum is a two's-complement register of a configurable width, and the bias is set at elaboration time.

Top module: `stream_mac`

## Requirements
- R1: A synchronous active-high reset clears `acc_out` to zero and drives `vld_out`, `sof_out` and `eof_out` low on the next clock edge. They stay that way until the first qualified input.
- R2: When `vld_in` and `sof_in` are both 1, `acc_out` in the next cycle equals `a_in*b_in + BIAS` for the operands of that cycle. For example, bias 8 with operands 1 and 1 gives 9.
- R3: When `vld_in` is 1 and `sof_in` is 0, `acc_out` in the next cycle equals the current `acc_out` plus `a_in*b_in`.
- R4: When `vld_in` is 0, `acc_out` keeps its value.
- R5: `vld_out` equals `vld_in` delayed by one cycle.
- R6: `sof_out` is 1 exactly one cycle after a cycle in which `vld_in` and `sof_in` were both 1. `eof_out` is 1 exactly one cycle after a cycle in which `vld_in` and `eof_in` were both 1.
- R7: `sof_in` and `eof_in` have no effect while `vld_in` is 0. In that case there is no reseed, and `sof_out` and `eof_out` stay low.
- R8: A cycle with `vld_in`, `sof_in` and `eof_in` all 1 yields a one-sample frame. The next cycle shows `acc_out` = product + bias, and `sof_out` and `eof_out` are both 1.
- R9: When `sof_in` stays 1 over consecutive qualified cycles, the sum is reseeded with bias plus product on each of those cycles.
- R10: A qualified sample that arrives before any frame-open marker adds its product onto the current register value. Right after reset that value is zero.
- R11: Operands are signed two's complement. The product is kept at full precision (2*DW bits) and sign-extended into the AW-bit sum, so -32768 * -32768 contributes +1073741824 at DW=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | DW | First operand, signed |
| b_in | input | DW | Second operand, signed |
| vld_in | input | 1 | Qualifies the operand pair and both markers |
| sof_in | input | 1 | Frame open: reseed the sum with bias plus product |
| eof_in | input | 1 | Frame close marker |
| acc_out | output | AW | Running sum, signed, registered |
| vld_out | output | 1 | `vld_in` delayed one cycle |
| sof_out | output | 1 | Qualified frame-open, delayed one cycle |
| eof_out | output | 1 | Qualified frame-close, delayed one cycle |

## Verification
The hardest case to reach from the ports is the interaction of the markers with the qualifier. Three situations matter here:
- markers raised while `vld_in` is low must leave both the sum and the output flags untouched;
- open and close in the same cycle must produce a one-sample frame;
- an open held high across several qualified cycles must reseed on each of them.

The bench drives dedicated sequences for each: an idle cycle with both markers high in the middle of a frame, a combined open-and-close cycle, and back-to-back open cycles followed by a plain accumulate. Because the sum is nonzero before each of these events, a missed or extra reseed changes the observed value.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    localparam int unsigned DEF_DW   = 16;
    localparam int unsigned DEF_AW   = 40;
    localparam int          DEF_BIAS = 8;

    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
    } flags_t;

    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_SEED = 2'd1,
        ACC_ADD  = 2'd2
    } acc_op_e;

    // Qualifier dominates; frame-open wins over plain accumulate.
    function automatic acc_op_e pick_op(input flags_t f);
        if (!f.vld)
            return ACC_HOLD;
        else if (f.sof)
            return ACC_SEED;
        else
            return ACC_ADD;
    endfunction

    function automatic flags_t gate_flags(input flags_t f);
        flags_t g;
        g.vld = f.vld;
        g.sof = f.vld & f.sof;
        g.eof = f.vld & f.eof;
        return g;
    endfunction

endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 40
) (
    input  logic signed [DW-1:0] a,
    input  logic signed [DW-1:0] b,
    output logic signed [AW-1:0] prod
);
    localparam int unsigned PW = 2 * DW;

    logic signed [PW-1:0] full;

    always_comb begin
        full = a * b;
        prod = AW'(full);
    end
endmodule

// File: rtl/fmac_acc.sv
module fmac_acc
    import fmac_pkg::*;
#(
    parameter int unsigned AW   = 40,
    parameter int          BIAS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  acc_op_e              op,
    input  logic signed [AW-1:0] prod,
    output logic signed [AW-1:0] acc
);
    localparam logic signed [AW-1:0] BIAS_V = AW'(BIAS);

    logic signed [AW-1:0] acc_nx;

    always_comb begin
        case (op)
            ACC_SEED: acc_nx = BIAS_V + prod;
            ACC_ADD:  acc_nx = acc + prod;
            default:  acc_nx = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else
            acc <= acc_nx;
    end

    // R4
    hold_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op == ACC_HOLD) |=> $stable(acc));
endmodule

// File: rtl/fmac_ctrl.sv
module fmac_ctrl
    import fmac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t fin,
    output flags_t fout
);
    always_ff @(posedge clk) begin
        if (rst)
            fout <= '0;
        else
            fout <= gate_flags(fin);
    end

    // R7
    flag_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (fout.sof || fout.eof) |-> fout.vld);
endmodule

// File: rtl/stream_mac.sv
module stream_mac
    import fmac_pkg::*;
#(
    parameter int unsigned DW   = DEF_DW,
    parameter int unsigned AW   = DEF_AW,
    parameter int          BIAS = DEF_BIAS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] a_in,
    input  logic signed [DW-1:0] b_in,
    input  logic                 vld_in,
    input  logic                 sof_in,
    input  logic                 eof_in,
    output logic signed [AW-1:0] acc_out,
    output logic                 vld_out,
    output logic                 sof_out,
    output logic                 eof_out
);
    localparam logic signed [AW-1:0] BIAS_V = AW'(BIAS);

    flags_t               fin;
    flags_t               fout;
    acc_op_e              op;
    logic signed [AW-1:0] prod;

    always_comb begin
        fin.vld = vld_in;
        fin.sof = sof_in;
        fin.eof = eof_in;
        op      = pick_op(fin);
    end

    fmac_mult #(.DW(DW), .AW(AW)) u_mult (
        .a    (a_in),
        .b    (b_in),
        .prod (prod)
    );

    fmac_acc #(.AW(AW), .BIAS(BIAS)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .prod (prod),
        .acc  (acc_out)
    );

    fmac_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .fin  (fin),
        .fout (fout)
    );

    assign vld_out = fout.vld;
    assign sof_out = fout.sof;
    assign eof_out = fout.eof;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_out == '0 && !vld_out && !sof_out && !eof_out));

    // R2
    seed_bias_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && sof_in) |=> (acc_out == $past(prod) + BIAS_V));

    // R3
    run_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && !sof_in) |=> (acc_out == $past(acc_out) + $past(prod)));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> (acc_out == $past(acc_out)));

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        vld_in |=> vld_out);

    // R6
    start_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && sof_in) |=> sof_out);

    // R6
    end_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (vld_in && eof_in) |=> eof_out);

    // R7
    idle_marks_chk: assert property (@(posedge clk) disable iff (rst)
        !vld_in |=> (!sof_out && !eof_out && !vld_out));
endmodule

// File: tb/sim_stream_mac.sv
module sim_stream_mac;
    localparam int unsigned DW   = 16;
    localparam int unsigned AW   = 40;
    localparam int          BIAS = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic signed [DW-1:0] a_in = '0;
    logic signed [DW-1:0] b_in = '0;
    logic                 vld_in = 1'b0;
    logic                 sof_in = 1'b0;
    logic                 eof_in = 1'b0;
    logic signed [AW-1:0] acc_out;
    logic                 vld_out, sof_out, eof_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    stream_mac #(.DW(DW), .AW(AW), .BIAS(BIAS)) u0 (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .vld_in(vld_in), .sof_in(sof_in), .eof_in(eof_in),
        .acc_out(acc_out), .vld_out(vld_out), .sof_out(sof_out), .eof_out(eof_out)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at falling edge, let the rising edge capture, sample 1 ns later
    task automatic cyc(input int a, input int b, input bit v, input bit s, input bit e);
        @(negedge clk);
        a_in = DW'(a); b_in = DW'(b);
        vld_in = v; sof_in = s; eof_in = e;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_flags(input string tag, input bit v, input bit s, input bit e);
        chk({tag, " vld_out"}, longint'(vld_out), longint'(v));
        chk({tag, " sof_out"}, longint'(sof_out), longint'(s));
        chk({tag, " eof_out"}, longint'(eof_out), longint'(e));
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        cyc(0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R1 acc after reset", longint'(acc_out), 0);
        chk_flags("R1", 0, 0, 0);
        @(negedge clk); rst = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk("R1 acc idle after reset", longint'(acc_out), 0);
    endtask

    task automatic t_pre_start();
        cyc(3, 4, 1, 0, 0);
        chk("R10 accumulate before start", longint'(acc_out), 12);
        chk_flags("R5 pre-start", 1, 0, 0);
    endtask

    task automatic t_frame();
        cyc(1, 1, 1, 1, 0);
        chk("R2 seed 1*1+8", longint'(acc_out), 9);
        chk_flags("R6 open", 1, 1, 0);
        cyc(2, 2, 1, 0, 0);
        chk("R3 add 2*2", longint'(acc_out), 13);
        cyc(-3, 5, 1, 0, 0);
        chk("R11 add -3*5", longint'(acc_out), -2);
        cyc(7, 7, 0, 1, 1);
        chk("R4 R7 hold with idle markers", longint'(acc_out), -2);
        chk_flags("R7 idle", 0, 0, 0);
        cyc(1, 4, 1, 0, 1);
        chk("R3 close add 1*4", longint'(acc_out), 2);
        chk_flags("R6 close", 1, 0, 1);
        cyc(9, 9, 0, 0, 0);
        chk("R4 hold after frame", longint'(acc_out), 2);
        chk_flags("R5 drop", 0, 0, 0);
    endtask

    task automatic t_single();
        cyc(5, 6, 1, 1, 1);
        chk("R8 single-sample frame", longint'(acc_out), 38);
        chk_flags("R8", 1, 1, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R4 hold after single", longint'(acc_out), 38);
    endtask

    task automatic t_restart();
        cyc(2, 3, 1, 1, 0);
        chk("R9 first open", longint'(acc_out), 14);
        cyc(4, 4, 1, 1, 0);
        chk("R9 reseed on repeated open", longint'(acc_out), 24);
        chk_flags("R9", 1, 1, 0);
        cyc(1, 1, 1, 0, 0);
        chk("R3 continue after reseed", longint'(acc_out), 25);
    endtask

    task automatic t_extremes();
        cyc(-32768, -32768, 1, 1, 0);
        chk("R11 min*min plus bias", longint'(acc_out), 64'sd1073741832);
        cyc(-32768, 32767, 1, 0, 0);
        chk("R11 add min*max", longint'(acc_out), 64'sd1073741832 - 64'sd1073709056);
    endtask

    task automatic t_reset_mid();
        cyc(3, 3, 1, 1, 1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid-stream reset acc", longint'(acc_out), 0);
        chk_flags("R1 mid-stream", 0, 0, 0);
        @(negedge clk); rst = 1'b0; vld_in = 1'b0; sof_in = 1'b0; eof_in = 1'b0;
        cyc(2, 5, 1, 0, 0);
        chk("R10 accumulate from zero after reset", longint'(acc_out), 10);
    endtask

    initial begin
        t_reset();
        t_pre_start();
        t_frame();
        t_single();
        t_restart();
        t_extremes();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule